// File: doc/BRIEF.md
# External Bus Mastership Handshake Controller

This block connects a processor's internal bus-access requester to an external bus arbiter. It raises a bus request toward the arbiter when the internal side needs the external bus, or when software forces the request on with a hold bit. It takes the arbiter's grant and watches a shared, open-drain bus-busy line. The device becomes master only when it has a grant and no other device still holds busy. It then drives busy itself and tells the requester when a new bus cycle may begin.

Mastership is parked: once owned, the bus stays owned while the grant remains, even when no accesses are pending. When the grant is withdrawn, the block waits for the end of the bus cycle in progress. It then releases busy by driving the line to its inactive level for one cycle and tri-stating it afterwards. Grant and busy can optionally pass through a two-flop synchronizer each, for arbiters that are not timed to this clock. Request, grant and busy are active-low at the pins.

Top module: `bus_own_ctrl`

## Requirements
- R1: During and right after reset, req_n is 1, is_master is 0, busy_oe is 0 and may_start is 0.
- R2: Outside low-power mode, req_n in the cycle after an edge is 0 if need_bus or hold_req was 1 at that edge, and 1 otherwise. This holds whether or not the block is master.
- R3: In low-power mode with hold_req at 0, req_n goes to 1 at the next edge. With hold_req at 1, req_n keeps its previous value.
- R4: The block becomes master only at an edge where the effective grant is asserted and the effective busy is deasserted (busy_n_in 1). While master it drives busy asserted: busy_oe is 1 and busy_n_out is 0.
- R5: If the grant is withdrawn while a bus cycle is in progress, mastership is kept until the edge at which cycle_end is 1. A cycle begins at an edge where may_start and need_bus are both 1.
- R6: While master with the grant asserted, mastership is kept whether or not need_bus or the request is asserted (bus parking).
- R7: Releasing mastership drives busy_oe 1 with busy_n_out 1 for exactly one cycle. In the following cycle busy_oe is 0.
- R8: With sync_en at 1, grant_n and busy_n_in each pass through two flip-flops before use, so mastership is taken two cycles later than with sync_en at 0, which uses them directly.
- R9: In low-power mode, grant and busy are ignored: a slave does not become master and a master does not release.
- R10: may_start is 1 only when the block is master, the effective grant is asserted, no bus cycle is in progress and low-power mode is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| need_bus | input | 1 | Internal side needs the external bus |
| hold_req | input | 1 | Software request-hold control bit |
| low_power | input | 1 | Stop or wait mode active |
| sync_en | input | 1 | Route grant and busy through synchronizers |
| cycle_end | input | 1 | Current external bus cycle ends at this edge |
| grant_n | input | 1 | Bus grant from arbiter, active-low |
| busy_n_in | input | 1 | Sampled level of the shared busy line, active-low |
| req_n | output | 1 | Bus request to arbiter, active-low |
| busy_n_out | output | 1 | Value driven on the busy line when enabled |
| busy_oe | output | 1 | Drive enable for the busy line |
| is_master | output | 1 | Block currently owns the external bus |
| may_start | output | 1 | A new bus cycle may begin this cycle |

## Verification
The properties assume that cycle_end is only pulsed while a bus cycle is in progress. They also assume that no other device drives the busy line while this block holds the grant. The stimulus follows both rules. It drives the busy line as the wired result of the block's own drive and a random external driver that stays quiet whenever the expected model is master or releasing. It raises cycle_end only while the model tracks a cycle in progress. Grant changes, low-power bursts and sync-mode changes are drawn at random with a fixed seed.

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_bus,
  input  logic hold_req,
  input  logic low_power,
  input  logic sync_en,
  input  logic cycle_end,
  input  logic grant_n,
  input  logic busy_n_in,
  output logic req_n,
  output logic busy_n_out,
  output logic busy_oe,
  output logic is_master,
  output logic may_start
);

  typedef enum logic [1:0] {ST_SLAVE, ST_MASTER, ST_RELEASE} st_t;

  st_t st;
  logic req_q, in_cycle;
  logic [SYNC_STAGES-1:0] gsh, bsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsh <= '0;
      bsh <= '0;
    end else begin
      gsh <= {gsh[SYNC_STAGES-2:0], ~grant_n};
      bsh <= {bsh[SYNC_STAGES-2:0], ~busy_n_in};
    end
  end

  wire gnt = sync_en ? gsh[SYNC_STAGES-1] : ~grant_n;
  wire bsy = sync_en ? bsh[SYNC_STAGES-1] : ~busy_n_in;

  assign is_master  = (st == ST_MASTER);
  assign busy_oe    = (st != ST_SLAVE);
  assign busy_n_out = (st == ST_RELEASE);
  assign may_start  = is_master && gnt && !in_cycle && !low_power;
  assign req_n      = ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      req_q <= 1'b0;
    else if (low_power)
      req_q <= hold_req ? req_q : 1'b0;
    else
      req_q <= need_bus || hold_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_SLAVE;
    end else begin
      case (st)
        ST_SLAVE:   if (!low_power && gnt && !bsy) st <= ST_MASTER;
        ST_MASTER:  if (!low_power && !gnt && (!in_cycle || cycle_end)) st <= ST_RELEASE;
        default:    st <= ST_SLAVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      in_cycle <= 1'b0;
    else if (st != ST_MASTER)
      in_cycle <= 1'b0;
    else if (may_start && need_bus)
      in_cycle <= 1'b1;
    else if (cycle_end)
      in_cycle <= 1'b0;
  end

endmodule

// File: rtl/bus_own_ctrl_chk.sv
module bus_own_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic low_power,
  input logic sync_en,
  input logic cycle_end,
  input logic grant_n,
  input logic req_n,
  input logic busy_n_out,
  input logic busy_oe,
  input logic is_master,
  input logic may_start,
  input logic in_cycle
);

  assert_lp_req_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !hold_req) |=> req_n);

  assert_lp_req_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && hold_req) |=> $stable(req_n));

  assert_master_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (busy_oe && !busy_n_out));

  assert_cycle_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && in_cycle && !cycle_end) |=> is_master);

  assert_parking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !sync_en && !grant_n) |=> is_master);

  assert_pullup_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(is_master) |-> (busy_oe && busy_n_out));

  assert_pullup_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(is_master) |=> !busy_oe);

  assert_lp_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !busy_oe) |=> !is_master);

  assert_lp_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && is_master) |=> is_master);

  assert_start_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    may_start |-> (is_master && !in_cycle && !low_power));

endmodule

bind bus_own_ctrl bus_own_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .low_power(low_power),
  .sync_en(sync_en), .cycle_end(cycle_end), .grant_n(grant_n),
  .req_n(req_n), .busy_n_out(busy_n_out), .busy_oe(busy_oe),
  .is_master(is_master), .may_start(may_start), .in_cycle(in_cycle)
);

// File: tb/sim_bus_own_ctrl.sv
`timescale 1ns/1ps
module sim_bus_own_ctrl;

  logic clk = 1'b0, rst_n = 1'b0;
  logic need_bus = 0, hold_req = 0, low_power = 0, sync_en = 0, cycle_end = 0;
  logic grant_n = 1, ext_busy_n = 1;
  logic req_n, busy_n_out, busy_oe, is_master, may_start;
  wire  busy_n_in = busy_oe ? busy_n_out : ext_busy_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_own_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .hold_req(hold_req),
    .low_power(low_power), .sync_en(sync_en), .cycle_end(cycle_end),
    .grant_n(grant_n), .busy_n_in(busy_n_in), .req_n(req_n),
    .busy_n_out(busy_n_out), .busy_oe(busy_oe), .is_master(is_master),
    .may_start(may_start)
  );

  // reference model: 0 slave, 1 master, 2 releasing
  int m_st;
  bit m_req, m_in, g1, g2, b1, b2;

  function automatic bit eff_g();
    return sync_en ? g2 : !grant_n;
  endfunction
  function automatic bit eff_b();
    return sync_en ? b2 : !busy_n_in;
  endfunction
  function automatic bit exp_may();
    return (m_st == 1) && eff_g() && !m_in && !low_power;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_req = 0; m_in = 0; g1 = 0; g2 = 0; b1 = 0; b2 = 0;
    end else begin
      bit g, b, ms;
      int nst;
      g = eff_g(); b = eff_b(); ms = exp_may();
      nst = m_st;
      if (m_st == 0 && !low_power && g && !b) nst = 1;
      else if (m_st == 1 && !low_power && !g && (!m_in || cycle_end)) nst = 2;
      else if (m_st == 2) nst = 0;
      if (m_st != 1) m_in = 0;
      else if (ms && need_bus) m_in = 1;
      else if (cycle_end) m_in = 0;
      if (low_power) m_req = hold_req ? m_req : 1'b0;
      else m_req = need_bus || hold_req;
      m_st = nst;
      g2 = g1; g1 = !grant_n; b2 = b1; b1 = !busy_n_in;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R2/R3 req_n", req_n, !m_req);
    chk("R4/R6/R9 is_master", is_master, m_st == 1);
    chk("R4/R7 busy_oe", busy_oe, m_st != 0);
    chk("R7 busy_n_out", busy_n_out, m_st == 2);
    chk("R10 may_start", may_start, exp_may());
  endtask

  task automatic do_reset();
    rst_n = 0; need_bus = 0; hold_req = 0; low_power = 0; cycle_end = 0;
    grant_n = 1; ext_busy_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 req_n", req_n, 1'b1);
    chk("R1 is_master", is_master, 1'b0);
    chk("R1 busy_oe", busy_oe, 1'b0);
    chk("R1 may_start", may_start, 1'b0);
    rst_n = 1;
  endtask

  function automatic int take_latency_expected(bit s);
    return s ? 3 : 1;
  endfunction

  task automatic measure(bit s, output int lat);
    sync_en = s;
    do_reset();
    step();
    grant_n = 0;
    lat = 0;
    for (int i = 0; i < 10 && !is_master; i++) begin
      step();
      lat++;
    end
  endtask

  initial begin
    int ld, ls;
    void'($urandom(32'h5eed_0042));

    // R8: synchronized mode takes mastership two cycles later
    measure(1'b0, ld);
    chk("R8 direct latency", ld == take_latency_expected(0), 1'b1);
    measure(1'b1, ls);
    chk("R8 sync latency", ls == take_latency_expected(1), 1'b1);
    chk("R8 latency difference", (ls - ld) == 2, 1'b1);

    // R4: busy held by another device blocks mastership
    sync_en = 0;
    do_reset();
    ext_busy_n = 0; grant_n = 0;
    repeat (3) step();
    chk("R4 wait for busy free", is_master, 1'b0);
    ext_busy_n = 1;
    step();
    chk("R4 take after busy free", is_master, 1'b1);

    // R6: parking with no request
    need_bus = 0;
    repeat (4) step();
    chk("R6 parked master", is_master, 1'b1);
    chk("R6 request off while parked", req_n, 1'b1);

    // R5: grant removed during a cycle
    need_bus = 1;
    step();
    need_bus = 0; grant_n = 1;
    repeat (3) step();
    chk("R5 kept during cycle", is_master, 1'b1);
    cycle_end = 1;
    step();
    cycle_end = 0;
    chk("R5/R7 release after cycle end", busy_n_out, 1'b1);
    step();
    chk("R7 line floats", busy_oe, 1'b0);

    // R9: grant ignored in low-power mode
    low_power = 1; grant_n = 0;
    repeat (3) step();
    chk("R9 no take in low power", is_master, 1'b0);
    low_power = 0;
    step();
    chk("R9 take after low power", is_master, 1'b1);

    // R3: hold keeps request in low power
    hold_req = 1;
    step();
    low_power = 1; hold_req = 1;
    repeat (2) step();
    chk("R3 hold keeps request", req_n, 1'b0);
    hold_req = 0;
    step();
    chk("R3 request dropped", req_n, 1'b1);
    low_power = 0;

    // constrained random phase
    for (int seg = 0; seg < 8; seg++) begin
      sync_en = seg[0];
      do_reset();
      for (int c = 0; c < 1500; c++) begin
        step();
        need_bus  = ($urandom % 10) < 6;
        hold_req  = ($urandom % 16) == 0 ? ~hold_req : hold_req;
        low_power = ($urandom % 32) == 0 ? ~low_power : low_power;
        if (($urandom % 8) == 0) grant_n = ~grant_n;
        cycle_end = m_in && (($urandom % 3) == 0);
        if (m_st != 0 || !grant_n) ext_busy_n = 1;
        else if (($urandom % 4) == 0) ext_busy_n = ~ext_busy_n;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule